// File: doc/BRIEF.md
# GPIO Interrupt Aggregation Controller

This block turns 32 general-purpose input lines into four summary interrupt lines for a main interrupt controller. Each line first passes through a two-stage synchroniser. A per-pin inversion bit then forms the pin's adjusted input value. Every pin can raise an interrupt in two ways. The level path is the adjusted value gated by a level-enable bit. The edge path holds a sticky capture bit that a 0-to-1 change of the adjusted value sets, gated by an edge-enable bit.

Because the inversion sits in front of both paths, one rising detector serves every edge mode. Rising edges use inversion 0 and falling edges use inversion 1. Both-edge operation comes from software toggling the inversion bit after each event. Only pins marked as inputs in the direction register take part. The causes of pins 8g to 8g+7 are ORed into summary output g.

Software reaches the registers through a simple synchronous bus: select, write enable, a 3-bit word offset, and write and read data. Read data is registered and is valid one cycle after the request.

Top module: `gpio_irq_agg`

## Requirements
- R1: After reset, the inversion, direction, level-enable, edge-enable and edge-capture registers all read 0, and all four summary outputs are low.
- R2: Each line passes through two flops before use. Word offset 0 reads the adjusted input, which is the synchronised line XOR the inversion register at offset 1. Writes to offset 0 have no effect.
- R3: A pin's level cause is its adjusted input AND its level-enable bit (offset 5). It has no memory and drops as soon as the adjusted input returns to 0.
- R4: A 0-to-1 change of a pin's adjusted input sets its edge-capture bit (offset 3). The bit stays set after the line returns. The edge cause is the capture bit AND the edge-enable bit (offset 4). With inversion 0 this catches rising line edges, and with inversion 1 it catches falling ones.
- R5: Writing 0 to an edge-capture bit clears it. Writing 1 leaves it unchanged.
- R6: When a new edge and a clearing write hit the same capture bit in the same cycle, the bit ends up set.
- R7: A write to the inversion register that moves a pin's adjusted input from 0 to 1 counts as an edge. Software flips the inversion bit after each event to get both-edge detection.
- R8: A pin whose direction bit (offset 2, 1 = input) is 0 raises no cause on either path, and its edge-capture bit does not set.
- R9: Summary output g is the registered OR of the causes of pins 8g to 8g+7. A pin's total cause is its level cause OR its edge cause.
- R10: Read data appears on the clock edge after a read request. Offsets 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | 32 | Asynchronous external lines |
| bus_sel | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_grp | output | 4 | Per-group summary interrupts |

## Verification
The assertions assume that bus requests last exactly one cycle, with the address and data stable during it. They also assume the external lines are asynchronous, so only the synchronised copy reaches the inversion stage. The bench changes the lines and the bus signals only on falling clock edges and holds each request for a single rising edge. The set-against-clear race is lined up by counting the two synchroniser stages, so that the clearing write lands on the exact edge where the capture bit sets.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int unsigned PIN_COUNT  = 32;
    localparam int unsigned GROUP_SIZE = 8;
    localparam int unsigned GROUP_CNT  = PIN_COUNT / GROUP_SIZE;
    localparam int unsigned OFF_W      = 3;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [OFF_W-1:0] {
        OFF_INPUT  = 3'd0,
        OFF_INVERT = 3'd1,
        OFF_DIR    = 3'd2,
        OFF_ECAP   = 3'd3,
        OFF_EEN    = 3'd4,
        OFF_LEN    = 3'd5
    } reg_off_e;

    typedef struct packed {
        logic                 sel;
        logic                 we;
        logic [OFF_W-1:0]     off;
        logic [PIN_COUNT-1:0] wdata;
    } bus_req_t;

    function automatic logic is_write(input bus_req_t r, input reg_off_e o);
        return r.sel && r.we && (r.off == o);
    endfunction

    function automatic logic is_read(input bus_req_t r);
        return r.sel && !r.we;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int unsigned W     = gpio_irq_pkg::PIN_COUNT,
    parameter int unsigned DEPTH = gpio_irq_pkg::SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage [DEPTH];

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage[DEPTH-1];

    // R2: the output is the input delayed through the flop chain
    a_r2_sync_delay: assert property (@(posedge clk) disable iff (rst)
        $past(rst) == 1'b0 |-> stage[1] == $past(stage[0]))
        else $error("sync chain broken");
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int unsigned W = PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  bus_req_t     req,
    input  logic [W-1:0] adj_in,
    input  logic [W-1:0] ecap,
    output logic [W-1:0] invert,
    output logic [W-1:0] dir_in,
    output logic [W-1:0] len,
    output logic [W-1:0] een,
    output logic [W-1:0] ecap_clr,
    output logic [W-1:0] rdata
);
    logic [W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            invert <= '0;
            dir_in <= '0;
            len    <= '0;
            een    <= '0;
        end else begin
            if (is_write(req, OFF_INVERT)) invert <= req.wdata;
            if (is_write(req, OFF_DIR))    dir_in <= req.wdata;
            if (is_write(req, OFF_LEN))    len    <= req.wdata;
            if (is_write(req, OFF_EEN))    een    <= req.wdata;
        end
    end

    always_comb begin
        ecap_clr = '0;
        if (is_write(req, OFF_ECAP)) ecap_clr = ~req.wdata;
    end

    always_comb begin
        case (reg_off_e'(req.off))
            OFF_INPUT:  rd_mux = adj_in;
            OFF_INVERT: rd_mux = invert;
            OFF_DIR:    rd_mux = dir_in;
            OFF_ECAP:   rd_mux = ecap;
            OFF_EEN:    rd_mux = een;
            OFF_LEN:    rd_mux = len;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)               rdata <= '0;
        else if (is_read(req)) rdata <= rd_mux;
    end

    // R10: offsets past the map return zero on the following cycle
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req.sel && !req.we && req.off > 3'd5) |=> rdata == '0)
        else $error("unmapped read nonzero");

    // R2: a write to the input offset leaves every writable register unchanged
    a_r2_input_ro: assert property (@(posedge clk) disable iff (rst)
        is_write(req, OFF_INPUT) |=> $stable(invert) && $stable(dir_in)
                                     && $stable(len) && $stable(een))
        else $error("write to input offset changed state");
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
    parameter int unsigned W = gpio_irq_pkg::PIN_COUNT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] adj_in,
    input  logic [W-1:0] dir_in,
    input  logic [W-1:0] clr,
    output logic [W-1:0] ecap
);
    logic [W-1:0] adj_q;
    logic [W-1:0] rise;

    always_ff @(posedge clk) begin
        if (rst) adj_q <= '0;
        else     adj_q <= adj_in;
    end

    assign rise = adj_in & ~adj_q & dir_in;

    // the set term sits outside the clear term, so a new edge wins (R6)
    always_ff @(posedge clk) begin
        if (rst) ecap <= '0;
        else     ecap <= (ecap & ~clr) | rise;
    end

    // R4/R6: a qualified rise always leaves its capture bit set
    a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ecap & $past(adj_in & ~adj_q & dir_in))
                 == $past(adj_in & ~adj_q & dir_in))
        else $error("edge lost");

    // R5: captured bits without a clear stay captured
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ecap & $past(ecap & ~clr)) == $past(ecap & ~clr))
        else $error("capture bit dropped");

    // R8: non-input pins never become captured
    a_r8_dir_gate: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ecap & ~$past(ecap) & ~$past(dir_in)) == '0)
        else $error("capture on non-input pin");
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
    parameter int unsigned W     = gpio_irq_pkg::PIN_COUNT,
    parameter int unsigned GSIZE = gpio_irq_pkg::GROUP_SIZE,
    localparam int unsigned NG   = W / GSIZE
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  cause,
    output logic [NG-1:0] irq
);
    generate
        for (genvar g = 0; g < NG; g++) begin : g_grp
            always_ff @(posedge clk) begin
                if (rst) irq[g] <= 1'b0;
                else     irq[g] <= |cause[g*GSIZE +: GSIZE];
            end
        end
    endgenerate

    // R9: no pin cause means every summary line falls on the next edge
    a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
        cause == '0 |=> irq == '0)
        else $error("summary without cause");
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
    import gpio_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PIN_COUNT-1:0]  gpio_in,
    input  logic                  bus_sel,
    input  logic                  bus_we,
    input  logic [OFF_W-1:0]      bus_addr,
    input  logic [PIN_COUNT-1:0]  bus_wdata,
    output logic [PIN_COUNT-1:0]  bus_rdata,
    output logic [GROUP_CNT-1:0]  irq_grp
);
    bus_req_t             req;
    logic [PIN_COUNT-1:0] line_s;
    logic [PIN_COUNT-1:0] adj_in;
    logic [PIN_COUNT-1:0] invert;
    logic [PIN_COUNT-1:0] dir_in;
    logic [PIN_COUNT-1:0] len;
    logic [PIN_COUNT-1:0] een;
    logic [PIN_COUNT-1:0] ecap;
    logic [PIN_COUNT-1:0] ecap_clr;
    logic [PIN_COUNT-1:0] cause;

    assign req = '{sel: bus_sel, we: bus_we, off: bus_addr, wdata: bus_wdata};

    gpio_irq_sync #(.W(PIN_COUNT), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (gpio_in),
        .sync_out (line_s)
    );

    assign adj_in = line_s ^ invert;

    gpio_irq_regs #(.W(PIN_COUNT)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .adj_in   (adj_in),
        .ecap     (ecap),
        .invert   (invert),
        .dir_in   (dir_in),
        .len      (len),
        .een      (een),
        .ecap_clr (ecap_clr),
        .rdata    (bus_rdata)
    );

    gpio_irq_edge #(.W(PIN_COUNT)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .adj_in (adj_in),
        .dir_in (dir_in),
        .clr    (ecap_clr),
        .ecap   (ecap)
    );

    assign cause = dir_in & ((adj_in & len) | (ecap & een));

    gpio_irq_group #(.W(PIN_COUNT), .GSIZE(GROUP_SIZE)) u_group (
        .clk   (clk),
        .rst   (rst),
        .cause (cause),
        .irq   (irq_grp)
    );

    // R1: the first cycle out of reset has quiet outputs
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> irq_grp == '0 && ecap == '0)
        else $error("not quiet after reset");

    // R8: with no input pins no summary line can rise
    a_r8_no_inputs: assert property (@(posedge clk) disable iff (rst)
        dir_in == '0 |=> irq_grp == '0)
        else $error("irq with no input pins");

    // R9: with both enables clear no summary line can rise
    a_r9_masked: assert property (@(posedge clk) disable iff (rst)
        (len == '0 && een == '0) |=> irq_grp == '0)
        else $error("irq while fully masked");

    // R3: an enabled, asserted level pin raises some summary line
    a_r3_level_raises: assert property (@(posedge clk) disable iff (rst)
        (dir_in & adj_in & len) != '0 |=> irq_grp != '0)
        else $error("level cause lost");
endmodule

// File: tb/tb_gpio_irq_agg.sv
module tb_gpio_irq_agg;
    import gpio_irq_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] gpio_in = '0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_grp;

    int total = 0;
    int bad = 0;
    bit done = 0;

    gpio_irq_agg dut (
        .clk(clk), .rst(rst), .gpio_in(gpio_in),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_grp(irq_grp)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cleanup();
        wr(OFF_DIR, '0); wr(OFF_LEN, '0); wr(OFF_EEN, '0); wr(OFF_INVERT, '0);
        gpio_in = '0;
        cyc(4);
        wr(OFF_ECAP, '0);
        cyc(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int a = 1; a <= 5; a++) begin
            rd(3'(a), d);
            chk("R1 reset register", d, 32'h0);
        end
        chk("R1 reset irq", {28'h0, irq_grp}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        gpio_in = 32'hA5A5_0F0F;
        wr(OFF_INVERT, 32'h0000_FFFF);
        cyc(3);
        rd(OFF_INPUT, d);
        chk("R2 adjusted input", d, 32'hA5A5_F0F0);
        wr(OFF_INPUT, 32'hFFFF_FFFF);
        rd(OFF_INPUT, d);
        chk("R2 input offset read-only", d, 32'hA5A5_F0F0);
        rd(OFF_INVERT, d);
        chk("R2 invert readback", d, 32'h0000_FFFF);
        wr(OFF_EEN, 32'h1234_5678);
        rd(OFF_EEN, d);
        chk("R10 edge-enable readback", d, 32'h1234_5678);
        rd(3'd6, d);
        chk("R10 offset 6 zero", d, 32'h0);
        rd(3'd7, d);
        chk("R10 offset 7 zero", d, 32'h0);
        cleanup();
    endtask

    task automatic t_level_high();
        wr(OFF_DIR, 32'h8); wr(OFF_LEN, 32'h8);
        gpio_in[3] = 1'b1; cyc(4);
        chk("R3 level high asserts", {28'h0, irq_grp}, 32'h1);
        gpio_in[3] = 1'b0; cyc(4);
        chk("R3 level follows line", {28'h0, irq_grp}, 32'h0);
        cleanup();
    endtask

    task automatic t_level_low();
        logic [31:0] d;
        wr(OFF_INVERT, 32'h1000); wr(OFF_DIR, 32'h1000); wr(OFF_LEN, 32'h1000);
        cyc(4);
        chk("R3 level low asserts", {28'h0, irq_grp}, 32'h2);
        rd(OFF_INPUT, d);
        chk("R2 inverted bit reads 1", d & 32'h1000, 32'h1000);
        gpio_in[12] = 1'b1; cyc(4);
        chk("R3 level low released", {28'h0, irq_grp}, 32'h0);
        cleanup();
    endtask

    task automatic t_rising();
        logic [31:0] d;
        wr(OFF_DIR, 32'h2_0000); wr(OFF_EEN, 32'h2_0000);
        gpio_in[17] = 1'b1; cyc(4);
        chk("R4 rising edge irq", {28'h0, irq_grp}, 32'h4);
        rd(OFF_ECAP, d);
        chk("R4 capture bit", d, 32'h2_0000);
        gpio_in[17] = 1'b0; cyc(4);
        chk("R4 sticky after line drops", {28'h0, irq_grp}, 32'h4);
        wr(OFF_ECAP, 32'hFFFF_FFFF); cyc(2);
        rd(OFF_ECAP, d);
        chk("R5 write 1 keeps bit", d, 32'h2_0000);
        wr(OFF_ECAP, 32'hFFFD_FFFF); cyc(2);
        rd(OFF_ECAP, d);
        chk("R5 write 0 clears", d, 32'h0);
        chk("R5 irq after clear", {28'h0, irq_grp}, 32'h0);
        cleanup();
    endtask

    task automatic t_falling();
        gpio_in[26] = 1'b1; cyc(4);
        wr(OFF_INVERT, 32'h0400_0000);
        wr(OFF_DIR, 32'h0400_0000); wr(OFF_EEN, 32'h0400_0000);
        cyc(2);
        chk("R4 no irq before falling", {28'h0, irq_grp}, 32'h0);
        gpio_in[26] = 1'b0; cyc(4);
        chk("R4 falling edge irq", {28'h0, irq_grp}, 32'h8);
        cleanup();
    endtask

    task automatic t_both();
        logic [31:0] d;
        wr(OFF_DIR, 32'h20); wr(OFF_EEN, 32'h20);
        gpio_in[5] = 1'b1; cyc(4);
        chk("R7 both-edge first rise", {28'h0, irq_grp}, 32'h1);
        wr(OFF_ECAP, 32'h0); wr(OFF_INVERT, 32'h20); cyc(3);
        chk("R7 flip to low-sense no edge", {28'h0, irq_grp}, 32'h0);
        gpio_in[5] = 1'b0; cyc(4);
        chk("R7 both-edge fall", {28'h0, irq_grp}, 32'h1);
        wr(OFF_ECAP, 32'h0); wr(OFF_INVERT, 32'h0); cyc(3);
        chk("R7 flip back no edge", {28'h0, irq_grp}, 32'h0);
        wr(OFF_INVERT, 32'h20); cyc(3);
        rd(OFF_ECAP, d);
        chk("R7 invert write makes edge", d, 32'h20);
        chk("R7 invert edge irq", {28'h0, irq_grp}, 32'h1);
        cleanup();
    endtask

    task automatic t_set_wins();
        logic [31:0] d;
        wr(OFF_DIR, 32'h600); wr(OFF_EEN, 32'h600);
        gpio_in[10] = 1'b1; cyc(4);
        gpio_in[9] = 1'b1;
        cyc(2);
        wr(OFF_ECAP, 32'h0);
        rd(OFF_ECAP, d);
        chk("R6 set beats clear", d, 32'h200);
        chk("R6 irq stays", {28'h0, irq_grp}, 32'h2);
        cleanup();
    endtask

    task automatic t_dir_gate();
        logic [31:0] d;
        wr(OFF_LEN, 32'h4000_0000); wr(OFF_EEN, 32'h4000_0000);
        gpio_in[30] = 1'b1; cyc(4);
        chk("R8 output pin level ignored", {28'h0, irq_grp}, 32'h0);
        gpio_in[30] = 1'b0; cyc(4);
        rd(OFF_ECAP, d);
        chk("R8 output pin no capture", d, 32'h0);
        cleanup();
    endtask

    task automatic t_groups();
        wr(OFF_DIR, 32'h8000_0181); wr(OFF_LEN, 32'h8000_0181);
        gpio_in = 32'h8000_0001; cyc(4);
        chk("R9 groups 0 and 3", {28'h0, irq_grp}, 32'h9);
        gpio_in = 32'h0000_0180; cyc(4);
        chk("R9 boundary pins 7 and 8", {28'h0, irq_grp}, 32'h3);
        gpio_in = 32'h0000_0080; cyc(4);
        chk("R9 single pin 7", {28'h0, irq_grp}, 32'h1);
        cleanup();
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        t_reset();
        t_regs();
        t_level_high();
        t_level_low();
        t_rising();
        t_falling();
        t_both();
        t_set_wins();
        t_dir_gate();
        t_groups();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule